// File: doc/BRIEF.md
# Light-Load Burst Supervisor

This block decides when a flyback controller gives up normal switching and drops into a low-power burst regime, how it switches while there, and when it returns to normal operation. It sees only digital flags: four feedback comparator outputs, the present valley-count setting of the normal-mode controller, and a current comparator flag for the reduced burst current level.

Burst mode is entered when the feedback flag for the entry level and a maximum valley count hold together for a blanking window. Inside burst mode, a hysteretic envelope turns on when feedback crosses the upper burst level and off when it falls below the lower one. While the envelope is on, a fixed-period timer starts a gate pulse every period. Each pulse ends on the current flag or at half the period, whichever comes first. A feedback rise above the exit level ends burst mode, and in that same step the block pulses a request that forces the valley counter back to 1.

Top module: `burst_supervisor`

## Requirements
- R1: After reset, `burst_mode`, `gate_cmd` and `valley_reset` are all 0.
- R2: `burst_mode` rises at the clock edge where `fb_below_entry` is high and `valley_cnt` equals `ENTRY_VALLEYS` (7) for the `BLANK_CYCLES`-th consecutive edge, and not at any earlier edge.
- R3: If either entry condition is absent at one edge, the blanking count restarts, and a further `BLANK_CYCLES` consecutive qualifying edges are needed.
- R4: On entry, switching is idle. `gate_cmd` stays 0 in burst mode until `fb_above_on` is seen.
- R5: One edge after `fb_above_on` is seen in burst mode, `gate_cmd` goes high. While the envelope stays on, `gate_cmd` repeats with period `PERIOD_CYCLES` and is high for `PERIOD_CYCLES/2` cycles of each period.
- R6: `cs_trip` seen at an edge while the gate is high ends that pulse at the same edge. The gate stays low until the next period begins.
- R7: `fb_below_off` seen in burst mode turns the envelope off at that edge. `gate_cmd` is then 0 until `fb_above_on` is seen again, and `burst_mode` stays 1.
- R8: `fb_above_exit` seen in burst mode clears `burst_mode` and `gate_cmd` at that edge and raises `valley_reset` for exactly that one following cycle.
- R9: Outside burst mode, `fb_above_on`, `fb_below_off` and `fb_above_exit` have no effect. `gate_cmd`, `burst_mode` and `valley_reset` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_below_entry | input | 1 | Feedback is below the entry level |
| fb_above_on | input | 1 | Feedback is above the burst-on level |
| fb_below_off | input | 1 | Feedback is below the burst-off level |
| fb_above_exit | input | 1 | Feedback is above the exit level |
| valley_cnt | input | CNT_W | Present valley-count setting |
| cs_trip | input | 1 | Current is above the burst current limit |
| burst_mode | output | 1 | Block is in burst mode |
| gate_cmd | output | 1 | Gate command during burst switching |
| valley_reset | output | 1 | One-cycle request to force the valley counter to 1 |

## Verification
The assertions assume that the comparator flags are already synchronous to `clk`. They also assume that `fb_above_on` and `fb_below_off` are never high together, because the analog levels make that impossible. The bench drives every flag one time unit after a rising edge and holds it for whole cycles. It raises the on and off flags only one at a time, so the outcome of the envelope never rests on a tie. The valley count is kept at or below 7, which is the range the counter it watches can hold.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_BURST  = 1'b1
   } bm_mode_e;
endpackage

// File: rtl/bm_entry_qual.sv
module bm_entry_qual #(
   parameter int CNT_W         = 3,
   parameter int ENTRY_VALLEYS = 7,
   parameter int BLANK_CYCLES  = 1200000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             fb_low,
   input  logic [CNT_W-1:0] valley,
   output logic             qualified
);
   localparam int            BW   = $clog2(BLANK_CYCLES + 1);
   localparam logic [BW-1:0] LAST = BW'(BLANK_CYCLES - 1);

   logic          cond;
   logic [BW-1:0] held_q;

   assign cond      = arm && fb_low && (valley == CNT_W'(ENTRY_VALLEYS));
   assign qualified = cond && (held_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             held_q <= '0;
      else if (!cond)         held_q <= '0;
      else if (held_q != LAST) held_q <= held_q + 1'b1;
   end

   // R3: a lost condition always restarts the window
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> held_q == '0);
endmodule

// File: rtl/bm_envelope.sv
module bm_envelope (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic on_req,
   input  logic off_req,
   output logic env_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       env_o <= 1'b0;
      else if (!enable) env_o <= 1'b0;
      else if (on_req)  env_o <= 1'b1;
      else if (off_req) env_o <= 1'b0;
   end

   // R7: an off request without an on request drops the envelope
   p_env_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      off_req && !on_req |=> !env_o);
endmodule

// File: rtl/bm_pwm.sv
module bm_pwm #(
   parameter int PERIOD_CYCLES = 962
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic trip,
   output logic gate_o
);
   localparam int            PW     = $clog2(PERIOD_CYCLES);
   localparam logic [PW-1:0] WRAP   = PW'(PERIOD_CYCLES - 1);
   localparam logic [PW-1:0] ON_MAX = PW'(PERIOD_CYCLES / 2);

   logic [PW-1:0] phase_q;
   logic          cut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         cut_q   <= 1'b0;
      end else if (!run) begin
         phase_q <= '0;
         cut_q   <= 1'b0;
      end else if (phase_q == WRAP) begin
         phase_q <= '0;
         cut_q   <= 1'b0;
      end else begin
         phase_q <= phase_q + 1'b1;
         if (trip) cut_q <= 1'b1;
      end
   end

   assign gate_o = run && (phase_q < ON_MAX) && !cut_q;

   // R6: a trip while the gate is high ends the pulse unless a period starts
   p_trip_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trip && gate_o |=> !gate_o || phase_q == '0);
   // R5: every pulse starts at the period boundary
   p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> phase_q == '0);
endmodule

// File: rtl/burst_supervisor.sv
module burst_supervisor #(
   parameter int CNT_W         = 3,
   parameter int ENTRY_VALLEYS = 7,
   parameter int BLANK_CYCLES  = 1200000,
   parameter int PERIOD_CYCLES = 962
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fb_below_entry,
   input  logic             fb_above_on,
   input  logic             fb_below_off,
   input  logic             fb_above_exit,
   input  logic [CNT_W-1:0] valley_cnt,
   input  logic             cs_trip,
   output logic             burst_mode,
   output logic             gate_cmd,
   output logic             valley_reset
);
   import bm_pkg::*;

   generate
      if (BLANK_CYCLES < 2) begin : g_bad_blank
         $error("BLANK_CYCLES must be at least 2");
      end
      if (PERIOD_CYCLES < 2) begin : g_bad_period
         $error("PERIOD_CYCLES must be at least 2");
      end
      if (ENTRY_VALLEYS >= (1 << CNT_W)) begin : g_bad_valley
         $error("ENTRY_VALLEYS does not fit in CNT_W bits");
      end
   endgenerate

   bm_mode_e mode_q;
   logic     enter;
   logic     in_burst;
   logic     env;
   logic     leave;
   logic     force_q;

   assign in_burst = (mode_q == MODE_BURST);
   assign leave    = in_burst && fb_above_exit;

   bm_entry_qual #(
      .CNT_W        (CNT_W),
      .ENTRY_VALLEYS(ENTRY_VALLEYS),
      .BLANK_CYCLES (BLANK_CYCLES)
   ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (!in_burst),
      .fb_low   (fb_below_entry),
      .valley   (valley_cnt),
      .qualified(enter)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_NORMAL;
         force_q <= 1'b0;
      end else begin
         force_q <= leave;
         if (leave)      mode_q <= MODE_NORMAL;
         else if (enter) mode_q <= MODE_BURST;
      end
   end

   bm_envelope u_env (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (in_burst && !fb_above_exit),
      .on_req (fb_above_on),
      .off_req(fb_below_off),
      .env_o  (env)
   );

   bm_pwm #(
      .PERIOD_CYCLES(PERIOD_CYCLES)
   ) u_pwm (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (env),
      .trip  (cs_trip),
      .gate_o(gate_cmd)
   );

   assign burst_mode   = in_burst;
   assign valley_reset = force_q;

   // R2: entry only follows both conditions
   p_entry_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_mode) |-> $past(fb_below_entry) && $past(valley_cnt) == CNT_W'(ENTRY_VALLEYS));
   // R8: exit and valley reset happen together, for one cycle
   p_exit_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_mode) |-> valley_reset);
   p_force_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valley_reset |=> !valley_reset);
   // R9: no gate activity outside burst mode
   p_gate_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gate_cmd |-> burst_mode);
endmodule

// File: tb/burst_supervisor_tb_top.sv
module burst_supervisor_tb_top;
   localparam int CNT_W  = 3;
   localparam int BLANK  = 40;
   localparam int PERIOD = 10;
   localparam int HALF   = PERIOD / 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fb_below_entry = 1'b0;
   logic             fb_above_on = 1'b0;
   logic             fb_below_off = 1'b0;
   logic             fb_above_exit = 1'b0;
   logic [CNT_W-1:0] valley_cnt = '0;
   logic             cs_trip = 1'b0;
   logic             burst_mode;
   logic             gate_cmd;
   logic             valley_reset;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   burst_supervisor #(
      .CNT_W        (CNT_W),
      .ENTRY_VALLEYS(7),
      .BLANK_CYCLES (BLANK),
      .PERIOD_CYCLES(PERIOD)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .fb_below_entry(fb_below_entry),
      .fb_above_on   (fb_above_on),
      .fb_below_off  (fb_below_off),
      .fb_above_exit (fb_above_exit),
      .valley_cnt    (valley_cnt),
      .cs_trip       (cs_trip),
      .burst_mode    (burst_mode),
      .gate_cmd      (gate_cmd),
      .valley_reset  (valley_reset)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset;
      check("R1 burst", burst_mode, 0);
      check("R1 gate", gate_cmd, 0);
      check("R1 valley_reset", valley_reset, 0);
   endtask

   task automatic t_outside_ignored;
      int hi = 0;
      valley_cnt = 3'd5;
      fb_above_on = 1'b1;  step(1); fb_above_on = 1'b0;
      fb_below_off = 1'b1; step(1); fb_below_off = 1'b0;
      fb_above_exit = 1'b1; step(1); fb_above_exit = 1'b0;
      for (int i = 0; i < 20; i++) begin
         hi += gate_cmd + valley_reset + burst_mode;
         step(1);
      end
      check("R9 no activity outside burst", hi, 0);
   endtask

   task automatic t_entry;
      fb_below_entry = 1'b1;
      valley_cnt = 3'd7;
      step(20);
      valley_cnt = 3'd6;
      step(1);
      valley_cnt = 3'd7;
      step(BLANK - 1);
      check("R3 window restarted", burst_mode, 0);
      step(1);
      check("R2 entered after window", burst_mode, 1);
      fb_below_entry = 1'b0;
   endtask

   task automatic t_entry_clean;
      fb_below_entry = 1'b1;
      valley_cnt = 3'd7;
      step(BLANK - 1);
      check("R2 not before window", burst_mode, 0);
      step(1);
      check("R2 entered", burst_mode, 1);
      fb_below_entry = 1'b0;
   endtask

   task automatic t_idle_on_entry;
      int hi = 0;
      for (int i = 0; i < 15; i++) begin
         hi += gate_cmd;
         step(1);
      end
      check("R4 idle until on flag", hi, 0);
   endtask

   task automatic t_pwm;
      int hi = 0;
      int g5 = 0;
      int g10 = 0;
      fb_above_on = 1'b1;
      step(1);
      fb_above_on = 1'b0;
      for (int i = 0; i < 3 * PERIOD; i++) begin
         hi += gate_cmd;
         if (i == 0) check("R5 gate high after on flag", gate_cmd, 1);
         if (i == HALF) g5 = gate_cmd;
         if (i == PERIOD) g10 = gate_cmd;
         step(1);
      end
      check("R5 high cycles in three periods", hi, 3 * HALF);
      check("R5 low at half period", g5, 0);
      check("R5 high at next period", g10, 1);
   endtask

   task automatic t_trip;
      check("R6 gate high at period start", gate_cmd, 1);
      cs_trip = 1'b1;
      step(1);
      cs_trip = 1'b0;
      check("R6 trip ends pulse", gate_cmd, 0);
      step(2);
      check("R6 stays low within period", gate_cmd, 0);
      step(PERIOD - 3);
      check("R6 next period restarts", gate_cmd, 1);
   endtask

   task automatic t_env_off;
      int hi = 0;
      fb_below_off = 1'b1;
      step(1);
      fb_below_off = 1'b0;
      for (int i = 0; i < 25; i++) begin
         hi += gate_cmd;
         step(1);
      end
      check("R7 no gate after off flag", hi, 0);
      check("R7 still in burst", burst_mode, 1);
   endtask

   task automatic t_exit;
      fb_above_on = 1'b1;
      step(1);
      fb_above_on = 1'b0;
      check("R8 gate running before exit", gate_cmd, 1);
      check("R8 no reset pulse yet", valley_reset, 0);
      fb_above_exit = 1'b1;
      step(1);
      fb_above_exit = 1'b0;
      check("R8 burst cleared", burst_mode, 0);
      check("R8 gate cleared", gate_cmd, 0);
      check("R8 valley reset pulse", valley_reset, 1);
      step(1);
      check("R8 pulse lasts one cycle", valley_reset, 0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_outside_ignored();
      t_entry();
      t_idle_on_entry();
      t_pwm();
      t_trip();
      t_env_off();
      t_exit();
      valley_cnt = 3'd2;
      t_outside_ignored();
      t_entry_clean();
      t_exit();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule